// File: doc/BRIEF.md
# Lockable Countdown Watchdog

This block is a watchdog countdown timer reached through a small word-addressed register port. Software sets a reload value and turns the timer on. After that it must keep clearing the timeout interrupt. The first expiry raises an interrupt. A second expiry while that interrupt is still pending pulses a reset output, provided reset generation is turned on.

A lock register protects the configuration. Any value written there other than the unlock key closes the lock. The key opens it again. A test register bit lets the count freeze while the debug-halt input is high, so that a halted processor is not reset by its own watchdog. The bus is single-cycle: writes take effect at the clock edge on which they are presented, and read data is combinational from the address.

Top module: `wdog_timer`

## Requirements
- R1: After reset the lock is open (offset 7 reads 0), the control register (offset 0) reads 0, the load register (offset 1) and live count (offset 2) read all ones, and the irq and rst_out outputs are 0.
- R2: Writing offset 0 with bit 0 set, while unlocked, starts the counter from the load value and turns the interrupt on. Bit 0 then reads back as 1, and no later write clears it.
- R3: Any write to offset 7 other than the unlock key closes the lock, and offset 7 then reads 1. While the lock is closed, writes to offsets 0 and 1 leave those registers unchanged.
- R4: Writing the key 0xC0DE5AFE to offset 7 opens the lock, and offset 7 then reads 0.
- R5: An unlocked write to offset 1 stores the reload value. If the timer is running, the same edge also copies that value into the count. A running count decrements once per cycle and, on the cycle after it reads 0, expires and reloads from offset 1, so the period is load+1 cycles.
- R6: An unlocked write of 0 to offset 1 sets the raw status on that same edge.
- R7: Offset 3 bit 0 is the raw timeout status. Offset 4 bit 0 and the irq output equal the raw status ANDed with the enable bit.
- R8: Writing offset 5 with bit 0 set clears the raw status. A write with bit 0 clear has no effect.
- R9: While offset 6 bit 0 is set and dbg_halt is high, the count holds. With that bit clear, the count runs whatever dbg_halt does.
- R10: When an expiry finds the raw status still set and control bit 1 (reset enable) is 1, rst_out goes high for exactly one cycle. With bit 1 clear, rst_out stays low.
- R11: Reads of offsets 8 to 15 and of offset 5 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register port select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | ADDR_W (4) | Word offset |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Combinational read data |
| dbg_halt | input | 1 | Processor halted by debugger |
| irq | output | 1 | Timeout interrupt |
| rst_out | output | 1 | One-cycle system reset request |

## Verification
Every register update, including the count reload on a running load write and the raw status set by a zero load, is visible on the read port right after the clock edge that carries the write. The bench therefore samples reads just after the following falling edge. A running count advances once per rising edge, and an expiry lands load+1 edges after the count was loaded. The bench counts those edges and reads the count or status at exactly those points. rst_out is registered off the expiry edge and is watched on every cycle of the window, so a pulse that comes early, comes late or lasts too long is caught.

// File: rtl/wdog_pkg.sv
`timescale 1ns/10ps
package wdog_pkg;
   // Word offsets of the register file
   localparam int unsigned OFS_CTRL  = 0;
   localparam int unsigned OFS_LOAD  = 1;
   localparam int unsigned OFS_COUNT = 2;
   localparam int unsigned OFS_RAW   = 3;
   localparam int unsigned OFS_MASK  = 4;
   localparam int unsigned OFS_CLEAR = 5;
   localparam int unsigned OFS_TEST  = 6;
   localparam int unsigned OFS_LOCK  = 7;

   // Control register bit positions
   localparam int unsigned CTRL_EN_BIT   = 0;
   localparam int unsigned CTRL_RSTE_BIT = 1;

   // Decoded write strobes from the bus
   typedef struct packed {
      logic ctrl;
      logic load;
      logic clr;
      logic test;
      logic lock;
   } wdog_wstb_t;
endpackage

// File: rtl/wdog_regs.sv
`timescale 1ns/10ps
module wdog_regs
   import wdog_pkg::*;
#(
   parameter int unsigned    DATA_W         = 32,
   parameter int unsigned    ADDR_W         = 4,
   parameter logic [DATA_W-1:0] UNLOCK_KEY  = 32'hC0DE5AFE,
   parameter logic [DATA_W-1:0] LOAD_RST    = '1,
   parameter bit             STALL_LOCKABLE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [DATA_W-1:0] count_i,
   input  logic              raw_i,
   output logic              en_o,
   output logic              rst_en_o,
   output logic              stall_o,
   output logic              locked_o,
   output logic [DATA_W-1:0] load_o,
   output logic              load_wr_o,
   output logic              en_set_o,
   output logic              clr_o
);
   localparam int unsigned NREG = 1 << ADDR_W;

   generate
      if (DATA_W < 2)  begin : g_bad_dw $error("DATA_W must be at least 2"); end
      if (ADDR_W < 3)  begin : g_bad_aw $error("ADDR_W must cover eight registers"); end
      if (NREG < 8)    begin : g_bad_nr $error("register space too small"); end
   endgenerate

   logic              wr;
   wdog_wstb_t        stb;
   logic              ctrl_ok;
   logic              test_ok;
   logic              en_q;
   logic              rst_en_q;
   logic              stall_q;
   logic              locked_q;
   logic [DATA_W-1:0] load_q;

   assign wr       = bus_sel & bus_wr;
   assign stb.ctrl = wr && (bus_addr == ADDR_W'(OFS_CTRL));
   assign stb.load = wr && (bus_addr == ADDR_W'(OFS_LOAD));
   assign stb.clr  = wr && (bus_addr == ADDR_W'(OFS_CLEAR));
   assign stb.test = wr && (bus_addr == ADDR_W'(OFS_TEST));
   assign stb.lock = wr && (bus_addr == ADDR_W'(OFS_LOCK));

   assign ctrl_ok   = stb.ctrl & ~locked_q;
   assign load_wr_o = stb.load & ~locked_q;
   assign en_set_o  = ctrl_ok & bus_wdata[CTRL_EN_BIT] & ~en_q;
   assign clr_o     = stb.clr & bus_wdata[0];

   // The stall bit may or may not sit behind the lock
   generate
      if (STALL_LOCKABLE) begin : g_test_locked
         assign test_ok = stb.test & ~locked_q;
      end else begin : g_test_open
         assign test_ok = stb.test;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         rst_en_q <= 1'b0;
         stall_q  <= 1'b0;
         locked_q <= 1'b0;
         load_q   <= LOAD_RST;
      end else begin
         if (ctrl_ok) begin
            if (bus_wdata[CTRL_EN_BIT]) en_q <= 1'b1;
            rst_en_q <= bus_wdata[CTRL_RSTE_BIT];
         end
         if (load_wr_o) load_q   <= bus_wdata;
         if (test_ok)   stall_q  <= bus_wdata[0];
         if (stb.lock)  locked_q <= (bus_wdata != UNLOCK_KEY);
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(OFS_CTRL): begin
            bus_rdata[CTRL_EN_BIT]   = en_q;
            bus_rdata[CTRL_RSTE_BIT] = rst_en_q;
         end
         ADDR_W'(OFS_LOAD):  bus_rdata    = load_q;
         ADDR_W'(OFS_COUNT): bus_rdata    = count_i;
         ADDR_W'(OFS_RAW):   bus_rdata[0] = raw_i;
         ADDR_W'(OFS_MASK):  bus_rdata[0] = raw_i & en_q;
         ADDR_W'(OFS_TEST):  bus_rdata[0] = stall_q;
         ADDR_W'(OFS_LOCK):  bus_rdata[0] = locked_q;
         default:            bus_rdata    = '0;
      endcase
   end

   assign en_o     = en_q;
   assign rst_en_o = rst_en_q;
   assign stall_o  = stall_q;
   assign locked_o = locked_q;
   assign load_o   = load_q;
endmodule

// File: rtl/wdog_counter.sv
`timescale 1ns/10ps
module wdog_counter #(
   parameter int unsigned       DATA_W   = 32,
   parameter logic [DATA_W-1:0] LOAD_RST = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              stall,
   input  logic              dbg_halt,
   input  logic [DATA_W-1:0] load_val,
   input  logic              load_wr,
   input  logic [DATA_W-1:0] load_data,
   input  logic              en_set,
   output logic [DATA_W-1:0] count_o,
   output logic              expire_o
);
   logic              tick;
   logic              force_load;
   logic [DATA_W-1:0] count_q;

   assign tick       = en & ~(stall & dbg_halt);
   assign force_load = load_wr & en;
   assign expire_o   = tick & ~force_load & (count_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= LOAD_RST;
      end else if (force_load) begin
         count_q <= load_data;
      end else if (en_set) begin
         count_q <= load_val;
      end else if (tick) begin
         count_q <= (count_q == '0) ? load_val : count_q - 1'b1;
      end
   end

   assign count_o = count_q;
endmodule

// File: rtl/wdog_intr.sv
`timescale 1ns/10ps
module wdog_intr (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic zero_load,
   input  logic clr,
   input  logic en,
   input  logic rst_en,
   output logic raw_o,
   output logic irq_o,
   output logic rst_o
);
   logic raw_q;
   logic rst_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         raw_q <= 1'b0;
         rst_q <= 1'b0;
      end else begin
         if (expire | zero_load) raw_q <= 1'b1;
         else if (clr)           raw_q <= 1'b0;
         rst_q <= expire & raw_q & rst_en & ~rst_q;
      end
   end

   assign raw_o = raw_q;
   assign irq_o = raw_q & en;
   assign rst_o = rst_q;
endmodule

// File: rtl/wdog_timer.sv
`timescale 1ns/10ps
module wdog_timer #(
   parameter int unsigned       DATA_W         = 32,
   parameter int unsigned       ADDR_W         = 4,
   parameter logic [DATA_W-1:0] UNLOCK_KEY     = 32'hC0DE5AFE,
   parameter bit                STALL_LOCKABLE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              dbg_halt,
   output logic              irq,
   output logic              rst_out
);
   localparam logic [DATA_W-1:0] LOAD_RST = '1;

   logic              lock_q;
   logic              en_q;
   logic              rst_en_q;
   logic              stall_q;
   logic              raw_q;
   logic [DATA_W-1:0] count_q;
   logic [DATA_W-1:0] load_q;
   logic              load_wr;
   logic              en_set;
   logic              clr;
   logic              expire;
   logic              zero_load;

   assign zero_load = load_wr & (bus_wdata == '0);

   wdog_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .UNLOCK_KEY(UNLOCK_KEY),
      .LOAD_RST(LOAD_RST), .STALL_LOCKABLE(STALL_LOCKABLE)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .count_i(count_q), .raw_i(raw_q),
      .en_o(en_q), .rst_en_o(rst_en_q), .stall_o(stall_q),
      .locked_o(lock_q), .load_o(load_q),
      .load_wr_o(load_wr), .en_set_o(en_set), .clr_o(clr)
   );

   wdog_counter #(.DATA_W(DATA_W), .LOAD_RST(LOAD_RST)) u_cnt (
      .clk(clk), .rst_n(rst_n), .en(en_q), .stall(stall_q),
      .dbg_halt(dbg_halt), .load_val(load_q), .load_wr(load_wr),
      .load_data(bus_wdata), .en_set(en_set),
      .count_o(count_q), .expire_o(expire)
   );

   wdog_intr u_intr (
      .clk(clk), .rst_n(rst_n), .expire(expire), .zero_load(zero_load),
      .clr(clr), .en(en_q), .rst_en(rst_en_q),
      .raw_o(raw_q), .irq_o(irq), .rst_o(rst_out)
   );
endmodule

// File: rtl/wdog_checker.sv
`timescale 1ns/10ps
module wdog_checker #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              dbg_halt,
   input logic              irq,
   input logic              rst_out,
   input logic              lock_q,
   input logic              en_q,
   input logic              rst_en_q,
   input logic              stall_q,
   input logic              raw_q,
   input logic [DATA_W-1:0] count_q,
   input logic [DATA_W-1:0] load_q
);
   logic wr_any;
   logic wr_load;
   assign wr_any  = bus_sel & bus_wr;
   assign wr_load = wr_any && (bus_addr == ADDR_W'(1));

   // R2: enable never drops once set
   p_en_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |=> en_q);

   // R3: locked load writes leave the reload value alone
   p_lock_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && wr_load) |=> $stable(load_q));

   // R6: zero load raises the raw status
   p_zero_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!lock_q && wr_load && bus_wdata == '0) |=> raw_q);

   // R7: interrupt only with enable
   p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (en_q && raw_q));

   // R9: stalled count holds while halted
   p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_q && dbg_halt && !wr_any) |=> $stable(count_q));

   // R10: reset request lasts one cycle
   p_rst_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rst_out |=> !rst_out);

   // R10: reset request only with pending status and reset enabled
   p_rst_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rst_out |-> ($past(raw_q) && $past(rst_en_q)));
endmodule

bind wdog_timer wdog_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .dbg_halt(dbg_halt),
   .irq(irq), .rst_out(rst_out), .lock_q(lock_q), .en_q(en_q),
   .rst_en_q(rst_en_q), .stall_q(stall_q), .raw_q(raw_q),
   .count_q(count_q), .load_q(load_q)
);

// File: tb/wdog_timer_tb.sv
`timescale 1ns/10ps
module wdog_timer_tb;
   localparam int unsigned DW  = 32;
   localparam int unsigned AW  = 4;
   localparam logic [31:0] KEY = 32'hC0DE5AFE;
   localparam int MAXCYC = 20000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          dbg_halt = 1'b0;
   logic          irq;
   logic          rst_out;

   int n_chk = 0;
   int n_bad = 0;
   logic [31:0] rv;

   always #2 clk = ~clk;

   wdog_timer u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .dbg_halt(dbg_halt), .irq(irq), .rst_out(rst_out)
   );

   typedef struct packed {
      logic        is_rd;
      logic [3:0]  addr;
      logic [31:0] data;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 24;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 4'd7, 32'h0,        8'd1},  // R1 lock open
      '{1'b1, 4'd0, 32'h0,        8'd1},  // R1 ctrl clear
      '{1'b1, 4'd1, 32'hFFFFFFFF, 8'd1},  // R1 load all ones
      '{1'b1, 4'd2, 32'hFFFFFFFF, 8'd1},  // R1 count all ones
      '{1'b0, 4'd1, 32'h55,       8'd5},  // R5 store reload
      '{1'b1, 4'd1, 32'h55,       8'd5},
      '{1'b0, 4'd7, 32'h1,        8'd3},  // R3 close lock
      '{1'b1, 4'd7, 32'h1,        8'd3},
      '{1'b0, 4'd1, 32'h77,       8'd3},  // R3 load ignored
      '{1'b1, 4'd1, 32'h55,       8'd3},
      '{1'b0, 4'd0, 32'h3,        8'd3},  // R3 ctrl ignored
      '{1'b1, 4'd0, 32'h0,        8'd3},
      '{1'b0, 4'd7, KEY,          8'd4},  // R4 open lock
      '{1'b1, 4'd7, 32'h0,        8'd4},
      '{1'b0, 4'd1, 32'h0,        8'd6},  // R6 zero load while stopped
      '{1'b1, 4'd3, 32'h1,        8'd6},
      '{1'b1, 4'd4, 32'h0,        8'd7},  // R7 masked stays low
      '{1'b0, 4'd5, 32'h0,        8'd8},  // R8 clear with bit 0 low
      '{1'b1, 4'd3, 32'h1,        8'd8},
      '{1'b0, 4'd5, 32'h1,        8'd8},  // R8 clear
      '{1'b1, 4'd3, 32'h0,        8'd8},
      '{1'b1, 4'd9, 32'h0,        8'd11}, // R11 undefined
      '{1'b1, 4'd15,32'h0,        8'd11}, // R11 undefined
      '{1'b1, 4'd5, 32'h0,        8'd11}  // R11 clear reads zero
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      bus_addr = a;
      #0.1;
      d = bus_rdata;
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (MAXCYC) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      int c;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 irq", {31'b0, irq}, 32'h0);
      check("R1 rst_out", {31'b0, rst_out}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i].is_rd) begin
            rd(VEC[i].addr, rv);
            check($sformatf("R%0d vec %0d", VEC[i].req, i), rv, VEC[i].data);
         end else begin
            wr(VEC[i].addr, VEC[i].data);
         end
      end

      // R2 / R5: start and count
      wr(4'd1, 32'd5);
      wr(4'd0, 32'h1);
      rd(4'd0, rv); check("R2 enable reads 1", rv, 32'h1);
      rd(4'd2, rv); check("R2 count loaded", rv, 32'd5);
      tick(3);
      rd(4'd2, rv); check("R5 decrement", rv, 32'd2);
      wr(4'd1, 32'd10);
      rd(4'd2, rv); check("R5 running reload", rv, 32'd10);
      tick(10);
      rd(4'd3, rv); check("R5 no expiry yet", rv, 32'h0);
      rd(4'd2, rv); check("R5 count at zero", rv, 32'd0);
      tick(1);
      rd(4'd3, rv); check("R5 expiry raw", rv, 32'h1);
      rd(4'd2, rv); check("R5 reload after expiry", rv, 32'd10);
      rd(4'd4, rv); check("R7 masked", rv, 32'h1);
      check("R7 irq", {31'b0, irq}, 32'h1);

      // R2 sticky enable
      wr(4'd0, 32'h0);
      rd(4'd0, rv); check("R2 enable sticky", rv, 32'h1);

      // R8 clear while running
      wr(4'd5, 32'h0);
      rd(4'd3, rv); check("R8 no-op clear", rv, 32'h1);
      wr(4'd5, 32'h1);
      rd(4'd3, rv); check("R8 clear", rv, 32'h0);
      check("R8 irq low", {31'b0, irq}, 32'h0);
      rd(4'd2, rv); check("R5 count track", rv, 32'd7);

      // R10 without reset enable: expiry at 8, second at 19
      c = 0;
      for (int i = 0; i < 19; i++) begin
         tick(1);
         if (rst_out) c++;
      end
      check("R10 no reset when disabled", c, 0);
      rd(4'd3, rv); check("R10 raw pending", rv, 32'h1);
      wr(4'd0, 32'h3);
      rd(4'd2, rv); check("R10 count before", rv, 32'd9);
      c = 0;
      for (int i = 1; i <= 11; i++) begin
         tick(1);
         check($sformatf("R10 rst_out cycle %0d", i), {31'b0, rst_out},
               (i == 10) ? 32'h1 : 32'h0);
      end

      // R9 stall
      wr(4'd6, 32'h1);
      dbg_halt = 1'b1;
      rd(4'd2, rv); c = int'(rv);
      check("R9 count before halt", rv, 32'd8);
      tick(5);
      rd(4'd2, rv); check("R9 held", rv, 32'd8);
      dbg_halt = 1'b0;
      tick(2);
      rd(4'd2, rv); check("R9 resumed", rv, 32'd6);
      wr(4'd6, 32'h0);
      dbg_halt = 1'b1;
      tick(2);
      rd(4'd2, rv); check("R9 no stall bit", rv, 32'd3);
      dbg_halt = 1'b0;

      // R6 zero load while running, reset disabled first
      wr(4'd0, 32'h1);
      wr(4'd5, 32'h1);
      rd(4'd3, rv); check("R6 raw cleared", rv, 32'h0);
      wr(4'd1, 32'h0);
      rd(4'd3, rv); check("R6 zero load raw", rv, 32'h1);
      check("R6 irq", {31'b0, irq}, 32'h1);

      // R3 lock while running
      wr(4'd7, 32'h0);
      wr(4'd1, 32'd40);
      rd(4'd1, rv); check("R3 load locked", rv, 32'h0);
      rd(4'd7, rv); check("R3 lock reads 1", rv, 32'h1);
      wr(4'd7, KEY);
      rd(4'd7, rv); check("R4 reopened", rv, 32'h0);

      // R1 reset returns defaults
      rst_n = 1'b0;
      tick(2);
      rst_n = 1'b1;
      rd(4'd0, rv); check("R1 ctrl after reset", rv, 32'h0);
      rd(4'd1, rv); check("R1 load after reset", rv, 32'hFFFFFFFF);
      check("R1 irq after reset", {31'b0, irq}, 32'h0);

      finish_run();
   end
endmodule